// File: doc/BRIEF.md
# Pseudo-SRAM Power Sequencer

This block drives the power-control enable of a pseudo-SRAM device. That pin is active high, and pulling it low puts the memory into its deep power-down state. The block also forces the active-low main chip enable to its inactive level whenever a power event is under way.

After the supply-good indication arrives, the block runs the start-up sequence. It holds the power-control enable low for a programmable number of clock cycles. It then raises that enable with the main enable already forced inactive, and keeps the main enable forced for a second, longer programmable window. Only after that window does it assert `ready_o`, which allows the access controller to issue reads and writes.

While ready, a power-down request starts an entry handshake. The request is honoured only once the access controller reports idle. The entry handshake is a setup window with the main enable forced inactive, then a low period on the power-control enable of at least a minimum length, then a wake-triggered exit hold before `ready_o` returns. One shared down-counter times every phase. With a 125 MHz clock the default counts cover the 50 µs low hold, the 350 µs wake hold and the nanosecond-scale entry and exit windows.

Top module: `psram_pwr_seq`

## Requirements
- R1: From reset until the cycle after `supply_ok_i` is first seen high, `ce2_o` is 0, `ce1_hold_o` is 1, `ready_o` is 0 and `dq_hiz_o` is 1.
- R2: After `supply_ok_i` is sampled high, `ce2_o` stays low for exactly T_C2L more cycles. It reads 1 on the (T_C2L+1)-th clock edge counted from the edge that sampled the supply good.
- R3: `ce1_hold_o` is 1 in every cycle from reset until `ready_o` first rises, and in particular in the cycle where `ce2_o` rises and the one before it.
- R4: `ready_o` rises exactly T_C1H clock edges after the edge on which `ce2_o` rose during start-up. In that same cycle `ce1_hold_o` falls to 0 and `dq_hiz_o` falls to 0.
- R5: While `ready_o` is 1 and `acc_idle_i` is 0, a power-down request has no effect: `ready_o` and `ce2_o` stay 1. A request withdrawn before the controller goes idle never starts an entry.
- R6: When `pd_req_i` and `acc_idle_i` are both 1 while ready, `ready_o` drops and `ce1_hold_o` rises on the next edge. `ce2_o` then falls T_PDS edges later, with `ce1_hold_o` already 1 in the preceding cycle.
- R7: Once low for power-down, `ce2_o` stays low for at least T_PDL cycles even if `wake_req_i` is already high. With no wake request it stays low indefinitely, with `dq_hiz_o` at 1.
- R8: When power-down ends, `ce2_o` rises with `ce1_hold_o` at 1 and `ready_o` at 0. `ready_o` returns exactly T_PDX edges after that rise. If wake arrives after the minimum low time, `ce2_o` rises on the first edge that samples it.
- R9: `dq_hiz_o` is 1 whenever `ce2_o` is 0.
- R10: `wake_req_i` has no effect outside power-down. `pd_req_i` has no effect before the first assertion of `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply has reached its minimum operating level |
| pd_req_i | input | 1 | Level request to enter power-down |
| wake_req_i | input | 1 | Level request to leave power-down |
| acc_idle_i | input | 1 | Access controller has no access in progress |
| ce2_o | output | 1 | Power-control enable to the memory (low = power-down) |
| ce1_hold_o | output | 1 | Forces the main chip enable inactive (high) |
| ready_o | output | 1 | Accesses may be issued |
| dq_hiz_o | output | 1 | Data pins must be kept high impedance |

## Verification
The bench measures every window edge-exact: the start-up low hold, the wake hold, the entry setup, the minimum power-down low time and the exit hold. A counter that is off by one therefore shows up as a wrong edge count. A design that honoured power-down during a busy access would drop `ready_o` while the busy flag is still up. Keeping the wake request high through entry exposes a design that cuts the minimum low period short. A late wake exposes a design that leaves power-down on its own. Stray wake requests while ready, and power-down requests during start-up, catch designs that react outside their phase.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

   typedef enum logic [2:0] {
      PWR_WAIT_SUPPLY = 3'd0,
      PWR_LOW_HOLD    = 3'd1,
      PWR_WAKE_HOLD   = 3'd2,
      PWR_RUN         = 3'd3,
      PWR_ENTER       = 3'd4,
      PWR_DOWN        = 3'd5,
      PWR_LEAVE       = 3'd6
   } pwr_state_e;

   typedef struct packed {
      logic ce2;
      logic ce1_hold;
      logic ready;
      logic hiz;
   } pwr_out_t;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // Pin levels implied by each phase.
   function automatic pwr_out_t decode_outputs(input pwr_state_e s);
      pwr_out_t o;
      case (s)
         PWR_WAKE_HOLD: o = '{ce2: 1'b1, ce1_hold: 1'b1, ready: 1'b0, hiz: 1'b1};
         PWR_RUN:       o = '{ce2: 1'b1, ce1_hold: 1'b0, ready: 1'b1, hiz: 1'b0};
         PWR_ENTER:     o = '{ce2: 1'b1, ce1_hold: 1'b1, ready: 1'b0, hiz: 1'b1};
         PWR_DOWN:      o = '{ce2: 1'b0, ce1_hold: 1'b1, ready: 1'b0, hiz: 1'b1};
         PWR_LEAVE:     o = '{ce2: 1'b1, ce1_hold: 1'b1, ready: 1'b0, hiz: 1'b1};
         default:       o = '{ce2: 1'b0, ce1_hold: 1'b1, ready: 1'b0, hiz: 1'b1};
      endcase
      return o;
   endfunction

endpackage

// File: rtl/psram_pwr_timer.sv
module psram_pwr_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             done_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done_o = (cnt_q == '0);

endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
   import psram_pwr_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned T_C2L = 6250,
   parameter int unsigned T_C1H = 43750,
   parameter int unsigned T_PDS = 2,
   parameter int unsigned T_PDL = 9,
   parameter int unsigned T_PDX = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             supply_ok_i,
   input  logic             pd_req_i,
   input  logic             wake_req_i,
   input  logic             acc_idle_i,
   input  logic             tdone_i,
   output pwr_state_e       state_q_o,
   output pwr_state_e       state_d_o,
   output logic             load_o,
   output logic [CNT_W-1:0] load_val_o
);

   localparam logic [CNT_W-1:0] LD_C2L = CNT_W'(T_C2L - 1);
   localparam logic [CNT_W-1:0] LD_C1H = CNT_W'(T_C1H - 1);
   localparam logic [CNT_W-1:0] LD_PDS = CNT_W'(T_PDS - 1);
   localparam logic [CNT_W-1:0] LD_PDL = CNT_W'(T_PDL - 1);
   localparam logic [CNT_W-1:0] LD_PDX = CNT_W'(T_PDX - 1);

   pwr_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         PWR_WAIT_SUPPLY: if (supply_ok_i)             state_d = PWR_LOW_HOLD;
         PWR_LOW_HOLD:    if (tdone_i)                 state_d = PWR_WAKE_HOLD;
         PWR_WAKE_HOLD:   if (tdone_i)                 state_d = PWR_RUN;
         PWR_RUN:         if (pd_req_i && acc_idle_i)  state_d = PWR_ENTER;
         PWR_ENTER:       if (tdone_i)                 state_d = PWR_DOWN;
         PWR_DOWN:        if (tdone_i && wake_req_i)   state_d = PWR_LEAVE;
         PWR_LEAVE:       if (tdone_i)                 state_d = PWR_RUN;
         default:                                      state_d = PWR_WAIT_SUPPLY;
      endcase
   end

   // Duration of the phase being entered, minus one: the phase lasts
   // exactly that many cycles before the timer reports done.
   always_comb begin
      case (state_d)
         PWR_LOW_HOLD:  load_val_o = LD_C2L;
         PWR_WAKE_HOLD: load_val_o = LD_C1H;
         PWR_ENTER:     load_val_o = LD_PDS;
         PWR_DOWN:      load_val_o = LD_PDL;
         PWR_LEAVE:     load_val_o = LD_PDX;
         default:       load_val_o = '0;
      endcase
   end

   assign load_o = (state_d != state_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= PWR_WAIT_SUPPLY;
      else         state_q <= state_d;
   end

   assign state_q_o = state_q;
   assign state_d_o = state_d;

endmodule

// File: rtl/psram_pwr_outstage.sv
module psram_pwr_outstage
   import psram_pwr_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  pwr_state_e state_q_i,
   input  pwr_state_e state_d_i,
   output pwr_out_t   out_o
);

   generate
      if (REG_OUT) begin : g_reg
         // Decode the next state into flops: same cycle timing as the
         // direct decode, but every pin leaves a flop.
         pwr_out_t out_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) out_q <= decode_outputs(PWR_WAIT_SUPPLY);
            else         out_q <= decode_outputs(state_d_i);
         end
         assign out_o = out_q;
         logic unused_q;
         assign unused_q = ^state_q_i;
      end else begin : g_comb
         assign out_o = decode_outputs(state_q_i);
         logic unused_d;
         assign unused_d = ^{clk_i, rst_ni, state_d_i};
      end
   endgenerate

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
   import psram_pwr_pkg::*;
#(
   parameter int unsigned T_C2L   = 6250,
   parameter int unsigned T_C1H   = 43750,
   parameter int unsigned T_PDS   = 2,
   parameter int unsigned T_PDL   = 9,
   parameter int unsigned T_PDX   = 2,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic supply_ok_i,
   input  logic pd_req_i,
   input  logic wake_req_i,
   input  logic acc_idle_i,
   output logic ce2_o,
   output logic ce1_hold_o,
   output logic ready_o,
   output logic dq_hiz_o
);

   localparam int unsigned MAX_DUR =
      max_u(max_u(T_C2L, T_C1H), max_u(max_u(T_PDS, T_PDL), T_PDX));
   localparam int unsigned CNT_W = $clog2(MAX_DUR + 1);

   generate
      if (T_C2L < 1 || T_C1H < 1 || T_PDS < 1 || T_PDL < 1 || T_PDX < 1) begin : g_bad_dur
         $error("psram_pwr_seq: every phase duration must be at least one cycle");
      end
   endgenerate

   pwr_state_e       state_q, state_d;
   logic             tload, tdone;
   logic [CNT_W-1:0] tval;
   pwr_out_t         pins;

   psram_pwr_fsm #(
      .CNT_W (CNT_W),
      .T_C2L (T_C2L),
      .T_C1H (T_C1H),
      .T_PDS (T_PDS),
      .T_PDL (T_PDL),
      .T_PDX (T_PDX)
   ) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .supply_ok_i (supply_ok_i),
      .pd_req_i    (pd_req_i),
      .wake_req_i  (wake_req_i),
      .acc_idle_i  (acc_idle_i),
      .tdone_i     (tdone),
      .state_q_o   (state_q),
      .state_d_o   (state_d),
      .load_o      (tload),
      .load_val_o  (tval)
   );

   psram_pwr_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (tload),
      .load_val_i (tval),
      .done_o     (tdone)
   );

   psram_pwr_outstage #(
      .REG_OUT (REG_OUT)
   ) u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .state_q_i (state_q),
      .state_d_i (state_d),
      .out_o     (pins)
   );

   assign ce2_o      = pins.ce2;
   assign ce1_hold_o = pins.ce1_hold;
   assign ready_o    = pins.ready;
   assign dq_hiz_o   = pins.hiz;

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
   parameter int unsigned MIN_LOW = 1
) (
   input logic clk_i,
   input logic rst_ni,
   input logic acc_idle_i,
   input logic ce2_o,
   input logic ce1_hold_o,
   input logic ready_o,
   input logic dq_hiz_o
);

   // Length of the current low run of the power-control enable.
   logic [31:0] low_run;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                low_run <= '0;
      else if (ce2_o)             low_run <= '0;
      else if (low_run != '1)     low_run <= low_run + 1'b1;
   end

   a_r3_hold_at_ce2_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ce2_o) |-> (ce1_hold_o && $past(ce1_hold_o)));

   a_r4_ready_needs_ce2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |-> (ce2_o && !ce1_hold_o));

   a_r5_busy_keeps_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && !acc_idle_i) |=> ready_o);

   a_r6_hold_before_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ce2_o) |-> ($past(ce1_hold_o) && !ready_o));

   a_r7_min_low_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ce2_o) |-> (low_run >= MIN_LOW));

   a_r8_ready_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ready_o) |-> $past(ce2_o));

   a_r9_hiz_when_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ce2_o |-> dq_hiz_o);

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
   .MIN_LOW ((T_PDL < T_C2L) ? T_PDL : T_C2L)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .acc_idle_i (acc_idle_i),
   .ce2_o      (ce2_o),
   .ce1_hold_o (ce1_hold_o),
   .ready_o    (ready_o),
   .dq_hiz_o   (dq_hiz_o)
);

// File: tb/psram_pwr_seq_bench.sv
module psram_pwr_seq_bench;

   localparam int C2L = 20;
   localparam int C1H = 30;
   localparam int PDS = 3;
   localparam int PDL = 5;
   localparam int PDX = 4;
   localparam int SEL_CE2 = 0;
   localparam int SEL_RDY = 1;

   logic clk = 1'b0;
   logic rst_n, supply_ok, pd_req, wake_req, acc_idle;
   logic ce2, ce1_hold, ready, hiz;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;

   always #4 clk = ~clk;

   psram_pwr_seq #(
      .T_C2L (C2L), .T_C1H (C1H), .T_PDS (PDS), .T_PDL (PDL), .T_PDX (PDX)
   ) u_psram_pwr_seq (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .supply_ok_i (supply_ok),
      .pd_req_i    (pd_req),
      .wake_req_i  (wake_req),
      .acc_idle_i  (acc_idle),
      .ce2_o       (ce2),
      .ce1_hold_o  (ce1_hold),
      .ready_o     (ready),
      .dq_hiz_o    (hiz)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic probe(input int sel);
      return (sel == SEL_CE2) ? ce2 : ready;
   endfunction

   // Edges (sampled at negedges) until the probed output takes val.
   task automatic wait_for(input int sel, input logic val, input int limit, output int k);
      k = -1;
      for (int i = 1; i <= limit; i++) begin
         @(negedge clk);
         if (probe(sel) == val) begin
            k = i;
            break;
         end
      end
   endtask

   task automatic t_reset_state();
      pd_req = 1'b1;  // R10: ignored before ready
      wake_req = 1'b1;
      repeat (6) @(negedge clk);
      check(ce2 == 1'b0 && ce1_hold == 1'b1, "R1", "ce2/ce1_hold in reset wait",
            {ce2, ce1_hold}, 2'b01);
      check(ready == 1'b0 && hiz == 1'b1, "R1", "ready/hiz in reset wait",
            {ready, hiz}, 2'b01);
      wake_req = 1'b0;
   endtask

   task automatic t_power_up();
      int  k;
      bit  hold_ok = 1'b1;
      supply_ok = 1'b1;
      wait_for(SEL_CE2, 1'b1, 200, k);
      check(k == C2L + 1, "R2", "edges until ce2 rises", k, C2L + 1);
      check(ce1_hold == 1'b1, "R3", "ce1_hold at ce2 rise", ce1_hold, 1);
      pd_req = 1'b0;
      k = -1;
      for (int i = 1; i <= 200; i++) begin
         @(negedge clk);
         if (ready) begin
            k = i;
            break;
         end
         if (!ce1_hold) hold_ok = 1'b0;
      end
      check(hold_ok, "R3", "ce1_hold high through wake hold", hold_ok, 1);
      check(k == C1H, "R4", "edges from ce2 rise to ready", k, C1H);
      check(ce1_hold == 1'b0 && hiz == 1'b0, "R4", "ce1_hold/hiz at ready",
            {ce1_hold, hiz}, 2'b00);
      check(pd_req == 1'b0 && ce2 == 1'b1, "R10", "pd_req during start-up ignored", ce2, 1);
   endtask

   task automatic t_wake_ignored();
      wake_req = 1'b1;
      repeat (8) @(negedge clk);
      check(ready == 1'b1 && ce2 == 1'b1, "R10", "wake while ready ignored",
            {ready, ce2}, 2'b11);
      wake_req = 1'b0;
   endtask

   task automatic t_withdrawn_request();
      acc_idle = 1'b0;
      pd_req = 1'b1;
      repeat (4) @(negedge clk);
      pd_req = 1'b0;
      @(negedge clk);
      acc_idle = 1'b1;
      repeat (5) @(negedge clk);
      check(ready == 1'b1 && ce2 == 1'b1, "R5", "withdrawn request no entry",
            {ready, ce2}, 2'b11);
   endtask

   task automatic t_deferred_entry_early_wake();
      int k;
      acc_idle = 1'b0;
      pd_req = 1'b1;
      wake_req = 1'b1;
      repeat (10) @(negedge clk);
      check(ready == 1'b1 && ce2 == 1'b1, "R5", "request deferred while busy",
            {ready, ce2}, 2'b11);
      acc_idle = 1'b1;
      wait_for(SEL_RDY, 1'b0, 20, k);
      check(k == 1, "R6", "edges until ready drops", k, 1);
      check(ce1_hold == 1'b1 && ce2 == 1'b1, "R6", "setup: ce1_hold high, ce2 still high",
            {ce1_hold, ce2}, 2'b11);
      pd_req = 1'b0;
      wait_for(SEL_CE2, 1'b0, 20, k);
      check(k == PDS, "R6", "edges from ready drop to ce2 fall", k, PDS);
      check(hiz == 1'b1, "R9", "hiz while powered down", hiz, 1);
      wait_for(SEL_CE2, 1'b1, 50, k);
      check(k == PDL, "R7", "low time with early wake", k, PDL);
      check(ce1_hold == 1'b1 && ready == 1'b0, "R8", "exit: hold high, not ready",
            {ce1_hold, ready}, 2'b10);
      wake_req = 1'b0;
      wait_for(SEL_RDY, 1'b1, 50, k);
      check(k == PDX, "R8", "edges from ce2 rise to ready", k, PDX);
   endtask

   task automatic t_late_wake();
      int k;
      pd_req = 1'b1;
      wait_for(SEL_CE2, 1'b0, 20, k);
      check(k == PDS + 1, "R6", "edges from idle request to ce2 fall", k, PDS + 1);
      pd_req = 1'b0;
      repeat (3 * PDL) @(negedge clk);
      check(ce2 == 1'b0 && hiz == 1'b1, "R7", "stays down without wake",
            {ce2, hiz}, 2'b01);
      wake_req = 1'b1;
      wait_for(SEL_CE2, 1'b1, 20, k);
      check(k == 1, "R8", "late wake rises next edge", k, 1);
      wake_req = 1'b0;
      wait_for(SEL_RDY, 1'b1, 50, k);
      check(k == PDX, "R8", "exit hold after late wake", k, PDX);
   endtask

   initial begin
      rst_n = 1'b0;
      supply_ok = 1'b0;
      pd_req = 1'b0;
      wake_req = 1'b0;
      acc_idle = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_power_up();
      t_wake_ignored();
      t_withdrawn_request();
      t_deferred_entry_early_wake();
      t_late_wake();
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule